// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

Two 16-bit down-counters share one byte-wide register port. Timer A counts every clock. Timer B counts either every clock or, in cascade mode, the underflows of timer A. In cascade mode B measures long intervals in units of A periods. Software can read B's live count after an event, then rewrite B's reload latch.

Each timer has a reload latch, a run bit, a one-shot selection and a force-load strobe. An underflow raises a sticky flag in a status register. Reading that register returns the flags and clears them. A mask selects which flags drive the interrupt output.

The cascade path is a fixed delay line. By default it is `CASC_DLY` (3) cycles long. Setting the `PHASE_LATE` parameter adds one more cycle, to model the chip variant whose timers run one cycle later.

Register map, on the 3-bit address:
- 0, 1: A low and high byte. Writes go to the latch; reads return the live count.
- 2, 3: B low and high byte, with the same behaviour.
- 4: A control.
- 5: B control.
- 6: status. Reads only; reading it clears the flags.
- 7: mask.

Control bits:
- bit 0: run.
- bit 3: one-shot.
- bit 4: force-load strobe.
- bit 6: cascade (B only).

Top module: `dual_timer`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF. Control, status and mask read 0, and irq_o is 0.
- R2: In clock mode with latch N, a running timer decrements once per cycle. It reloads N in the cycle after it reads 1, so underflows come every N cycles. A timer started at cycle w first decrements at the edge that ends cycle w+1.
- R3: In cascade mode (bit 6 of address 5), timer B decrements only on an A underflow, and only 3 cycles after that underflow (4 with PHASE_LATE). A B underflow therefore shows in status 3 cycles after the A underflow that caused it.
- R4: In cascade mode timer B counts down to 0 and reloads on the next tick. With A latch N and B latch M, B underflows every (M+1)*N cycles.
- R5: A write to a low latch byte changes only the latch. A write to a high latch byte also loads the counter, as {new high, latch low}, but only while that timer is stopped.
- R6: Writing control with bit 4 set copies the latch into the counter at that edge. Bit 4 always reads back as 0.
- R7: In one-shot mode (bit 3), an underflow clears the run bit (bit 0) and leaves the counter holding the latch value.
- R8: Status bit 0 (A) and bit 1 (B) are set by underflows and stay set. A read of address 6 with rd_en_i clears them. An underflow in the same cycle as the clearing read wins.
- R9: Status bit 7 and irq_o are 1 exactly when a flag is set whose mask bit (address 7, bits 1:0) is 1.
- R10: Reads are combinational on addr_i. Control reads return run, one-shot and cascade in their write positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; needed to clear status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Masked underflow interrupt |

## Verification
The assertions assume that a cycle with no write leaves every timer's configuration untouched. For that reason the counting properties are qualified with the absence of wr_en_i rather than with specific addresses. The stimulus holds each write for exactly one edge. It changes addresses and strobes only at falling edges. It polls status with rd_en_i held high, so every flag shows up as a single-cycle pulse whose timing can be measured. The cascade test uses an A period well above the cascade delay, so each B underflow can be matched to the A underflow that caused it.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int NTIM   = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_A_LO = 3'd0;
  localparam logic [ADDR_W-1:0] RA_A_HI = 3'd1;
  localparam logic [ADDR_W-1:0] RA_B_LO = 3'd2;
  localparam logic [ADDR_W-1:0] RA_B_HI = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CTLA = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CTLB = 3'd5;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd6;
  localparam logic [ADDR_W-1:0] RA_MASK = 3'd7;

  localparam int CB_RUN   = 0;
  localparam int CB_ONESH = 3;
  localparam int CB_FORCE = 4;
  localparam int CB_CASC  = 6;
endpackage

// File: rtl/dtim_counter.sv
module dtim_counter
  import dtim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              zero_mode_i,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ctl_wr_i,
  input  logic              start_i,
  input  logic              oneshot_i,
  input  logic              force_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              run_o,
  output logic              oneshot_o,
  output logic              uf_o
);
  logic [CNT_W-1:0] cnt_q, lat_q;
  logic run_q, os_q, at_end, ld_now;

  // zero mode: reload after showing 0; clock mode: reload after showing 1
  assign at_end = zero_mode_i ? (cnt_q == '0) : (cnt_q <= CNT_W'(1));
  assign ld_now = ctl_wr_i & force_i;
  assign uf_o   = run_q & tick_i & at_end & ~ld_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '1;
    end else if (lo_wr_i) begin
      lat_q[DATA_W-1:0] <= byte_i;
    end else if (hi_wr_i) begin
      lat_q[CNT_W-1:DATA_W] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (ld_now) begin
      cnt_q <= lat_q;
    end else if (hi_wr_i && !run_q) begin
      cnt_q <= {byte_i, lat_q[DATA_W-1:0]};
    end else if (uf_o) begin
      cnt_q <= lat_q;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      os_q  <= 1'b0;
    end else if (ctl_wr_i) begin
      run_q <= start_i;
      os_q  <= oneshot_i;
    end else if (uf_o && os_q) begin
      run_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign oneshot_o = os_q;
endmodule

// File: rtl/dtim_delay.sv
module dtim_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stg_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/dtim_irq.sv
module dtim_irq
  import dtim_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NTIM-1:0] uf_i,
  input  logic            rd_clr_i,
  input  logic            mask_wr_i,
  input  logic [NTIM-1:0] mask_i,
  output logic [NTIM-1:0] flags_o,
  output logic [NTIM-1:0] mask_o,
  output logic            irq_o
);
  logic [NTIM-1:0] flags_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      // a new underflow beats the clearing read
      flags_q <= (rd_clr_i ? '0 : flags_q) | uf_i;
      if (mask_wr_i) mask_q <= mask_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtim_pkg::*;
#(
  parameter int CASC_DLY   = 3,
  parameter bit PHASE_LATE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PIPE_DEPTH = CASC_DLY + int'(PHASE_LATE);

  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic run_a, run_b, os_a, os_b, uf_a, uf_b;
  logic casc_q, pipe_out, tick_b;
  logic [NTIM-1:0] flags, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             casc_q <= 1'b0;
    else if (wr_en_i && addr_i == RA_CTLB)   casc_q <= wdata_i[CB_CASC];
  end

  dtim_counter u_tim_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(1'b1), .zero_mode_i(1'b0),
    .lo_wr_i(wr_en_i && addr_i == RA_A_LO), .hi_wr_i(wr_en_i && addr_i == RA_A_HI),
    .byte_i(wdata_i), .ctl_wr_i(wr_en_i && addr_i == RA_CTLA),
    .start_i(wdata_i[CB_RUN]), .oneshot_i(wdata_i[CB_ONESH]), .force_i(wdata_i[CB_FORCE]),
    .cnt_o(cnt_a), .run_o(run_a), .oneshot_o(os_a), .uf_o(uf_a)
  );

  dtim_delay #(.DEPTH(PIPE_DEPTH)) u_casc_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(uf_a), .q_o(pipe_out)
  );

  assign tick_b = casc_q ? pipe_out : 1'b1;

  dtim_counter u_tim_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_b), .zero_mode_i(casc_q),
    .lo_wr_i(wr_en_i && addr_i == RA_B_LO), .hi_wr_i(wr_en_i && addr_i == RA_B_HI),
    .byte_i(wdata_i), .ctl_wr_i(wr_en_i && addr_i == RA_CTLB),
    .start_i(wdata_i[CB_RUN]), .oneshot_i(wdata_i[CB_ONESH]), .force_i(wdata_i[CB_FORCE]),
    .cnt_o(cnt_b), .run_o(run_b), .oneshot_o(os_b), .uf_o(uf_b)
  );

  dtim_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .uf_i({uf_b, uf_a}),
    .rd_clr_i(rd_en_i && addr_i == RA_STAT),
    .mask_wr_i(wr_en_i && addr_i == RA_MASK), .mask_i(wdata_i[NTIM-1:0]),
    .flags_o(flags), .mask_o(mask), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_A_LO: rdata_o = cnt_a[DATA_W-1:0];
      RA_A_HI: rdata_o = cnt_a[CNT_W-1:DATA_W];
      RA_B_LO: rdata_o = cnt_b[DATA_W-1:0];
      RA_B_HI: rdata_o = cnt_b[CNT_W-1:DATA_W];
      RA_CTLA: begin
        rdata_o[CB_RUN]   = run_a;
        rdata_o[CB_ONESH] = os_a;
      end
      RA_CTLB: begin
        rdata_o[CB_RUN]   = run_b;
        rdata_o[CB_ONESH] = os_b;
        rdata_o[CB_CASC]  = casc_q;
      end
      RA_STAT: begin
        rdata_o[NTIM-1:0]   = flags;
        rdata_o[DATA_W-1]   = |(flags & mask);
      end
      RA_MASK: rdata_o[NTIM-1:0] = mask;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dtim_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b,
  input logic              run_a,
  input logic              run_b,
  input logic              os_a,
  input logic              uf_a,
  input logic              uf_b,
  input logic              casc_q,
  input logic              tick_b,
  input logic [NTIM-1:0]   flags
);
  AST_A_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_a && !wr_en_i && cnt_a > CNT_W'(1) |=> cnt_a == $past(cnt_a) - CNT_W'(1)); // R2

  AST_CASC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_q && !tick_b && !wr_en_i |=> $stable(cnt_b)); // R3

  AST_CASC_REACH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_q && run_b && tick_b && cnt_b == CNT_W'(1) && !wr_en_i |=> cnt_b == '0); // R4

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_a && os_a && !wr_en_i |=> !run_a); // R7

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_a |=> flags[0]); // R8

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == RA_STAT && !uf_a && !uf_b |=> flags == '0); // R8

  AST_IRQ_BIT7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == RA_STAT |-> rdata_o[DATA_W-1] == irq_o); // R9

  always_comb begin
    if (addr_i == RA_CTLA || addr_i == RA_CTLB)
      AST_STROBE_ZERO: assert (!rdata_o[CB_FORCE]); // R6
  end
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .cnt_a(cnt_a), .cnt_b(cnt_b), .run_a(run_a),
  .run_b(run_b), .os_a(os_a), .uf_a(uf_a), .uf_b(uf_b), .casc_q(casc_q),
  .tick_b(tick_b), .flags(flags)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  localparam int DLY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  wire  [7:0] rdata;
  wire        irq;

  dual_timer u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
                 .wdata_i(wd), .rdata_o(rdata), .irq_o(irq));

  int n_run = 0, n_fail = 0;
  int qa[$], qb[$];

  // behavioural reference
  int m_cnt[2], m_lat[2];
  bit m_run[2], m_os[2];
  bit m_casc;
  bit [1:0] m_flag, m_mask;
  bit m_q[$];

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_cnt[0] & 255;
      1: return m_cnt[0] >> 8;
      2: return m_cnt[1] & 255;
      3: return m_cnt[1] >> 8;
      4: return int'(m_run[0]) | (int'(m_os[0]) << 3);
      5: return int'(m_run[1]) | (int'(m_os[1]) << 3) | (int'(m_casc) << 6);
      6: return int'(m_flag) | (((m_flag & m_mask) != 0) ? 128 : 0);
      default: return int'(m_mask);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 16'hFFFF; m_lat[i] = 16'hFFFF; m_run[i] = 0; m_os[i] = 0;
      end
      m_casc = 0; m_flag = 0; m_mask = 0;
      m_q = {};
      for (int i = 0; i < DLY; i++) m_q.push_back(1'b0);
    end else begin
      bit tk_b, uf[2];
      tk_b = m_q[0];
      for (int i = 0; i < 2; i++) begin
        bit frc, endc, tk, cw;
        cw   = wr && addr == 3'(4 + i);
        frc  = cw && wd[4];
        endc = (i == 1 && m_casc) ? (m_cnt[i] == 0) : (m_cnt[i] <= 1);
        tk   = (i == 1 && m_casc) ? tk_b : 1'b1;
        uf[i] = m_run[i] && tk && endc && !frc;
        if (frc) m_cnt[i] = m_lat[i];
        else if (wr && addr == 3'(2*i+1) && !m_run[i]) m_cnt[i] = (int'(wd) << 8) | (m_lat[i] & 255);
        else if (uf[i]) m_cnt[i] = m_lat[i];
        else if (m_run[i] && tk) m_cnt[i] = m_cnt[i] - 1;
        if (wr && addr == 3'(2*i))   m_lat[i] = (m_lat[i] & 16'hFF00) | int'(wd);
        if (wr && addr == 3'(2*i+1)) m_lat[i] = (m_lat[i] & 255) | (int'(wd) << 8);
        if (cw) begin m_run[i] = wd[0]; m_os[i] = wd[3]; end
        else if (uf[i] && m_os[i]) m_run[i] = 0;
      end
      if (wr && addr == 3'd5) m_casc = wd[6];
      m_flag = ((rd && addr == 3'd6) ? 2'b00 : m_flag) | {uf[1], uf[0]};
      if (wr && addr == 3'd7) m_mask = wd[1:0];
      void'(m_q.pop_front());
      m_q.push_back(uf[0]);
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      chk("R10 model read", int'(rdata), m_read(int'(addr)));
      chk("R9 model irq", int'(irq), ((m_flag & m_mask) != 0) ? 1 : 0);
    end
  end

  task automatic wreg(int a, int d);
    @(negedge clk); addr = 3'(a); wd = 8'(d); wr = 1'b1; rd = 1'b0;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rdchk(int a, int exp, bit clr, string req);
    @(negedge clk); addr = 3'(a); wr = 1'b0; rd = clr;
    #1 chk(req, int'(rdata), exp);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(int n);
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic poll(int n);
    @(negedge clk); addr = 3'd6; wr = 1'b0; rd = 1'b1;
    qa.delete(); qb.delete();
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      if (rdata[0]) qa.push_back(k);
      if (rdata[1]) qb.push_back(k);
    end
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 8; a++) rdchk(a, (a < 4) ? 8'hFF : 0, 1'b0, "R1 reset value");
    chk("R1 irq after reset", int'(irq), 0);

    // R5 latch vs counter
    wreg(0, 5);
    rdchk(0, 8'hFF, 1'b0, "R5 low write leaves counter");
    wreg(1, 0);
    rdchk(0, 5, 1'b0, "R5 high write loads stopped counter");

    // R2 clock-mode period
    wreg(7, 3);
    wreg(4, 1);
    poll(40);
    chk("R2 underflow count", (qa.size() >= 3) ? 1 : 0, 1);
    if (qa.size() >= 3) begin
      chk("R2 period 1", qa[1] - qa[0], 5);
      chk("R2 period 2", qa[2] - qa[1], 5);
    end
    wreg(4, 0);

    // R6 force load
    wreg(0, 8'h30);
    wreg(4, 8'h10);
    rdchk(0, 8'h30, 1'b0, "R6 force load low");
    rdchk(1, 0, 1'b0, "R6 force load high");
    rdchk(4, 0, 1'b0, "R6 strobe reads zero");

    // R5 high write while running
    wreg(4, 1);
    wreg(1, 8'h12);
    rdchk(1, 0, 1'b0, "R5 running counter not loaded");
    wreg(4, 0);

    // R7 one-shot, R8/R9 status
    wreg(0, 8);
    wreg(1, 0);
    rdchk(6, 0, 1'b1, "R8 flags clear before one-shot");
    wreg(4, 8'h09);
    idle(15);
    rdchk(4, 8'h08, 1'b0, "R7 run bit cleared");
    rdchk(0, 8, 1'b0, "R7 counter holds latch");
    chk("R9 irq on enabled flag", int'(irq), 1);
    rdchk(6, 8'h81, 1'b1, "R8 R9 flag with bit7");
    rdchk(6, 0, 1'b1, "R8 cleared by read");

    wreg(7, 2);
    wreg(4, 8'h09);
    idle(15);
    chk("R9 masked flag no irq", int'(irq), 0);
    rdchk(6, 8'h01, 1'b1, "R9 masked flag no bit7");

    // R3/R4 cascade
    wreg(7, 3);
    wreg(0, 10); wreg(1, 0);
    wreg(2, 2);  wreg(3, 0);
    wreg(5, 8'h41);
    rdchk(5, 8'h41, 1'b0, "R10 control readback");
    wreg(4, 1);
    poll(120);
    chk("R4 B underflow count", (qb.size() >= 2) ? 1 : 0, 1);
    if (qb.size() >= 2) chk("R4 cascade period (M+1)*N", qb[1] - qb[0], 30);
    if (qb.size() >= 1) begin
      int last_a = -1000;
      foreach (qa[j]) if (qa[j] <= qb[0]) last_a = qa[j];
      chk("R3 cascade delay", qb[0] - last_a, DLY);
    end
    wreg(4, 0);
    wreg(5, 0);
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule